// File: doc/BRIEF.md
# Masked Interrupt Controller with Acknowledge Readout

This block keeps an 8-bit register of pending interrupt events and an 8-bit enable mask. It drives an active-low interrupt line to the host. Two kinds of source set pending bits. The first is a free-running one-second tick. The second is a peripheral-bus event, which is either an explicit transaction result or an automatic poll result. The peripheral bus itself sits outside the block. It is seen here only through a byte-write port into a small reply buffer and an event strobe that carries a byte count.

The host drives the block through a single-beat command port with two operations, selected by `cmd_op`:

- `0` loads the mask.
- `1` acknowledges pending events.

An acknowledge streams a reply, one byte per cycle, on the response port. When a bus event is pending, the reply is a flag byte followed by the buffered bus reply, and only the bus-related bits are cleared. Otherwise the reply is one byte holding the whole pending register, and that register is cleared.

The reply is produced by a sequencer with five states:

- **IDLE** waits for a command. It moves to **FLAG** when an acknowledge with no argument bytes is taken.
- **FLAG** sends the flag byte. It returns to **IDLE** if no bus event was pending. It moves to **DATA** for a poll reply. It moves to **MARK** for an explicit reply.
- **MARK** sends the explicit marker byte (0x01 when data is present, 0x00 when none is present). It moves to **LEN** when data is present, and otherwise returns to **IDLE**.
- **LEN** sends the byte count and moves to **DATA**.
- **DATA** streams the buffer bytes from index 0. It returns to **IDLE** after the last byte.

Top module: `irq_ack_ctrl`

## Requirements
- R1: `irq_n` is 0 exactly when the bitwise AND of the pending register and the mask is nonzero. Otherwise it is 1. Pending bit positions are: bit 0 = bus event, bit 1 = bus autopoll, bit 2 = tick.
- R2: After reset the pending register is 0 and the mask is 0x05, which enables the bus and tick bits. After reset `irq_n` = 1, `cmd_ready` = 1 and `rsp_valid` = 0.
- R3: The tick bit is set once every CLK_PER_MS*TICK_MS cycles. The first set happens on the clock edge that number of cycles after reset. The period runs freely and is not shifted by acknowledges.
- R4: A command with `cmd_op` = 0 and `cmd_argc` = 1 replaces the mask with `cmd_arg` and produces no reply. A command with `cmd_op` = 0 and any other `cmd_argc` leaves the mask unchanged.
- R5: A command with `cmd_op` = 1 and `cmd_argc` not equal to 0 is rejected. It produces no reply and leaves the pending register unchanged.
- R6: An accepted acknowledge with bit 0 clear replies with one byte equal to the pending register, with `rsp_last` set. The pending register is then cleared, except for a tick that arrives in that same cycle.
- R7: An accepted acknowledge with bit 0 set replies first with a flag byte equal to the pending register ANDed with 0x03. The stored bus reply follows. Bits 0 and 1 and the stored length are then cleared, and the other bits are kept.
- R8: A poll event (`bev_poll` = 1) is taken only when `bev_len` is nonzero and bit 0 is clear. It sets bits 0 and 1, and its stored reply is the `bev_len` buffer bytes alone. Any other poll event is ignored.
- R9: An explicit event (`bev_poll` = 0) sets bit 0. Its stored reply is 0x01, the length, then the buffer bytes when `bev_len` > 0. When `bev_len` = 0 the stored reply is the single byte 0x00.
- R10: Buffer writes are ignored while bit 0 is pending or a reply is streaming. Bus events are ignored while a reply is streaming and in the cycle a command is taken.
- R11: An event length greater than DEPTH is reduced to DEPTH.
- R12: A reply appears on the cycle after the command is taken, one byte per cycle. `rsp_last` marks the final byte. `cmd_ready` is 0 while a reply is streaming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 1 | 0 = load mask, 1 = acknowledge |
| cmd_argc | input | 4 | Number of argument bytes carried |
| cmd_arg | input | 8 | First argument byte |
| cmd_ready | output | 1 | Block can take a command |
| rsp_valid | output | 1 | Reply byte valid |
| rsp_data | output | 8 | Reply byte |
| rsp_last | output | 1 | Final reply byte |
| bw_en | input | 1 | Reply buffer write strobe |
| bw_addr | input | AW | Reply buffer byte index |
| bw_data | input | 8 | Reply buffer byte |
| bev_valid | input | 1 | Bus event strobe |
| bev_poll | input | 1 | 1 = poll result, 0 = explicit result |
| bev_len | input | LW | Bus reply byte count |
| irq_n | output | 1 | Active-low interrupt line |

## Verification
The bench builds the block with DEPTH = 4, CLK_PER_MS = 2 and TICK_MS = 50. This gives a tick period of 100 cycles, so the first tick and the free-running second tick can both be timed to the exact cycle within a short run. A buffer of four bytes lets a 3-bit event length of 7 exceed the depth, which exercises the length clamp. The smaller settings leave every reply format unchanged: poll replies, explicit replies with and without data, and single-byte replies.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
    localparam int unsigned PEND_W   = 8;
    localparam int unsigned BIT_BUS  = 0;
    localparam int unsigned BIT_POLL = 1;
    localparam int unsigned BIT_TICK = 2;
    localparam logic [PEND_W-1:0] MASK_RST = 8'h05;
    localparam logic [PEND_W-1:0] BUS_BITS = 8'h03;

    typedef enum logic [1:0] {RK_POLL, RK_DATA, RK_NONE} reply_kind_e;
    typedef enum logic [2:0] {S_IDLE, S_FLAG, S_MARK, S_LEN, S_DATA} seq_state_e;
    typedef enum logic {OP_SETMASK = 1'b0, OP_ACK = 1'b1} cmd_op_e;
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
    parameter int unsigned CLK_PER_MS = 1000,
    parameter int unsigned TICK_MS    = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned PERIOD = CLK_PER_MS * TICK_MS;
    localparam int unsigned CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    // Free-running: the next target is always one period after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/irq_reply_buf.sv
module irq_reply_buf
    import irq_ack_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned AW    = $clog2(DEPTH),
    parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_lock,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          ev_take,
    input  logic          ev_poll,
    input  logic [LW-1:0] ev_len,
    input  logic          clear,
    input  logic [LW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic [LW-1:0] len_q,
    output reply_kind_e   kind_q
);
    logic [7:0]    mem [DEPTH];
    logic [LW-1:0] len_eff;

    assign len_eff = (ev_len > LW'(DEPTH)) ? LW'(DEPTH) : ev_len;

    always_ff @(posedge clk) begin
        if (wr_en && !wr_lock && ({1'b0, wr_addr} < (AW + 1)'(DEPTH)))
            mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            kind_q <= RK_NONE;
        end else if (ev_take) begin
            len_q  <= len_eff;
            kind_q <= ev_poll ? RK_POLL : ((len_eff == '0) ? RK_NONE : RK_DATA);
        end else if (clear) begin
            len_q  <= '0;
        end
    end

    assign rd_data = (rd_addr < LW'(DEPTH)) ? mem[rd_addr[AW-1:0]] : 8'h00;
endmodule

// File: rtl/irq_reply_fsm.sv
module irq_reply_fsm
    import irq_ack_pkg::*;
#(
    parameter int unsigned LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          with_bus,
    input  logic [7:0]    flag,
    input  reply_kind_e   kind,
    input  logic [LW-1:0] len,
    input  logic [7:0]    rd_data,
    output logic [LW-1:0] rd_addr,
    output logic          busy,
    output logic          rsp_valid,
    output logic [7:0]    rsp_data,
    output logic          rsp_last
);
    seq_state_e    state_q, state_d;
    logic [7:0]    flag_q;
    logic          bus_q;
    reply_kind_e   kind_q;
    logic [LW-1:0] len_q, cnt_q;
    logic          data_end;

    assign data_end = (cnt_q == len_q - LW'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_FLAG;
            S_FLAG: begin
                if (!bus_q)                state_d = S_IDLE;
                else if (kind_q == RK_POLL) state_d = S_DATA;
                else                       state_d = S_MARK;
            end
            S_MARK: state_d = (kind_q == RK_DATA) ? S_LEN : S_IDLE;
            S_LEN:  state_d = S_DATA;
            S_DATA: if (data_end) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            flag_q  <= '0;
            bus_q   <= 1'b0;
            kind_q  <= RK_NONE;
            len_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start) begin
                flag_q <= flag;
                bus_q  <= with_bus;
                kind_q <= kind;
                len_q  <= len;
                cnt_q  <= '0;
            end else if (state_q == S_DATA) begin
                cnt_q  <= cnt_q + LW'(1);
            end
        end
    end

    always_comb begin
        rsp_valid = (state_q != S_IDLE);
        rsp_data  = 8'h00;
        rsp_last  = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_FLAG: begin
                rsp_data = flag_q;
                rsp_last = !bus_q;
            end
            S_MARK: begin
                rsp_data = (kind_q == RK_DATA) ? 8'h01 : 8'h00;
                rsp_last = (kind_q != RK_DATA);
            end
            S_LEN:  rsp_data = 8'(len_q);
            S_DATA: begin
                rsp_data = rd_data;
                rsp_last = data_end;
            end
            default: ;
        endcase
    end

    assign busy    = (state_q != S_IDLE);
    assign rd_addr = cnt_q;
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import irq_ack_pkg::*;
#(
    parameter int unsigned DEPTH      = 8,
    parameter int unsigned CLK_PER_MS = 1000,
    parameter int unsigned TICK_MS    = 1000,
    localparam int unsigned AW        = $clog2(DEPTH),
    localparam int unsigned LW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_op,
    input  logic [3:0]    cmd_argc,
    input  logic [7:0]    cmd_arg,
    output logic          cmd_ready,
    output logic          rsp_valid,
    output logic [7:0]    rsp_data,
    output logic          rsp_last,
    input  logic          bw_en,
    input  logic [AW-1:0] bw_addr,
    input  logic [7:0]    bw_data,
    input  logic          bev_valid,
    input  logic          bev_poll,
    input  logic [LW-1:0] bev_len,
    output logic          irq_n
);
    logic [PEND_W-1:0] pend_q, pend_d, mask_q, ack_flag;
    logic              tick, busy, cmd_take, mask_ok, ack_ok, bus_pend, ev_take;
    logic [LW-1:0]     buf_len, rd_addr;
    logic [7:0]        rd_data;
    reply_kind_e       buf_kind;

    assign bus_pend = pend_q[BIT_BUS];
    assign cmd_take = cmd_valid && !busy;
    assign mask_ok  = cmd_take && (cmd_op == OP_SETMASK) && (cmd_argc == 4'd1);
    assign ack_ok   = cmd_take && (cmd_op == OP_ACK) && (cmd_argc == 4'd0);
    assign ev_take  = bev_valid && !busy && !cmd_take &&
                      (!bev_poll || ((bev_len != '0) && !bus_pend));
    assign ack_flag = bus_pend ? (pend_q & BUS_BITS) : pend_q;

    irq_tick_gen #(.CLK_PER_MS(CLK_PER_MS), .TICK_MS(TICK_MS)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    irq_reply_buf #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bw_en), .wr_lock(bus_pend || busy), .wr_addr(bw_addr), .wr_data(bw_data),
        .ev_take(ev_take), .ev_poll(bev_poll), .ev_len(bev_len),
        .clear(ack_ok && bus_pend),
        .rd_addr(rd_addr), .rd_data(rd_data), .len_q(buf_len), .kind_q(buf_kind)
    );

    irq_reply_fsm #(.LW(LW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start(ack_ok), .with_bus(bus_pend), .flag(ack_flag),
        .kind(buf_kind), .len(buf_len), .rd_data(rd_data), .rd_addr(rd_addr),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last)
    );

    always_comb begin
        pend_d = pend_q;
        if (ack_ok) pend_d = bus_pend ? (pend_q & ~BUS_BITS) : '0;
        if (tick)   pend_d[BIT_TICK] = 1'b1;
        if (ev_take) begin
            pend_d[BIT_BUS] = 1'b1;
            if (bev_poll) pend_d[BIT_POLL] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= MASK_RST;
        end else begin
            pend_q <= pend_d;
            if (mask_ok) mask_q <= cmd_arg;
        end
    end

    assign irq_n     = ~|(pend_q & mask_q);
    assign cmd_ready = !busy;
endmodule

// File: rtl/irq_ack_ctrl_chk.sv
module irq_ack_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_op,
    input logic [3:0] cmd_argc,
    input logic [7:0] cmd_arg,
    input logic       cmd_ready,
    input logic       rsp_valid,
    input logic [7:0] rsp_data,
    input logic       rsp_last,
    input logic [7:0] pend_q,
    input logic [7:0] mask_q
);
    logic take;
    assign take = cmd_valid && cmd_ready;

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        take && !cmd_op && cmd_argc == 4'd1 |=> mask_q == $past(cmd_arg)); // R4
    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        take && !cmd_op && cmd_argc != 4'd1 |=> $stable(mask_q)); // R4
    AST_ACK_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        take && cmd_op && cmd_argc != 4'd0 |=> !rsp_valid); // R5
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        take && cmd_op && cmd_argc == 4'd0 && !pend_q[0]
        |=> rsp_valid && rsp_last && rsp_data == $past(pend_q)); // R6
    AST_ACK_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        take && cmd_op && cmd_argc == 4'd0 && pend_q[0]
        |=> rsp_valid && !rsp_last && rsp_data == ($past(pend_q) & 8'h03)
            && pend_q[1:0] == 2'b00); // R7
    AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> rsp_valid); // R12
    AST_BUSY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready); // R12
endmodule

bind irq_ack_ctrl irq_ack_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_argc(cmd_argc), .cmd_arg(cmd_arg), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .pend_q(pend_q), .mask_q(mask_q)
);

// File: tb/sim_irq_ack_ctrl.sv
module sim_irq_ack_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4, CPM = 2, TMS = 50, T = CPM * TMS;

    logic       clk = 0, rst_n = 0;
    logic       cmd_valid = 0, cmd_op = 0;
    logic [3:0] cmd_argc = 0;
    logic [7:0] cmd_arg = 0;
    logic       cmd_ready, rsp_valid, rsp_last, irq_n;
    logic [7:0] rsp_data;
    logic       bw_en = 0, bev_valid = 0, bev_poll = 0;
    logic [1:0] bw_addr = 0;
    logic [7:0] bw_data = 0;
    logic [2:0] bev_len = 0;

    int n_chk = 0, n_bad = 0, cyc = 0, rn = 0, ready_bad = 0;
    logic [7:0] rb [16];

    irq_ack_ctrl #(.DEPTH(DEPTH), .CLK_PER_MS(CPM), .TICK_MS(TMS)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_argc(cmd_argc), .cmd_arg(cmd_arg), .cmd_ready(cmd_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .bw_en(bw_en), .bw_addr(bw_addr), .bw_data(bw_data),
        .bev_valid(bev_valid), .bev_poll(bev_poll), .bev_len(bev_len), .irq_n(irq_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic run_cmd(input logic op, input logic [3:0] argc, input logic [7:0] arg);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_argc = argc; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 0;
        rn = 0; ready_bad = 0;
        for (int i = 0; i < 20; i++) begin
            if (!rsp_valid) break;
            if (cmd_ready) ready_bad++;
            rb[rn] = rsp_data; rn++;
            if (rsp_last) break;
            @(negedge clk);
        end
    endtask

    task automatic buf_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bw_en = 1; bw_addr = a; bw_data = d;
        @(negedge clk); bw_en = 0;
    endtask

    task automatic bus_ev(input logic poll, input logic [2:0] len);
        @(negedge clk); bev_valid = 1; bev_poll = poll; bev_len = len;
        @(negedge clk); bev_valid = 0;
    endtask

    task automatic t_reset();
        chk("R2 ready", int'(cmd_ready), 1);
        chk("R2 irq_n", int'(irq_n), 1);
        chk("R2 rsp_valid", int'(rsp_valid), 0);
    endtask

    task automatic t_tick();
        for (int i = 0; i < 3 * T && irq_n; i++) @(negedge clk);
        chk("R3 first tick cycle (R2 mask)", cyc, T);
        run_cmd(1, 0, 0);
        chk("R6 reply length", rn, 1);
        chk("R6 tick reply byte", int'(rb[0]), 8'h04);
        chk("R6 R1 irq released", int'(irq_n), 1);
        for (int i = 0; i < 3 * T && irq_n; i++) @(negedge clk);
        chk("R3 second tick free-running", cyc, 2 * T);
        run_cmd(1, 0, 0);
    endtask

    task automatic t_mask();
        run_cmd(0, 1, 8'h01);
        chk("R4 set mask gives no reply", rn, 0);
        while (cyc < 3 * T + 2) @(negedge clk);
        chk("R4 R1 tick masked", int'(irq_n), 1);
        run_cmd(0, 2, 8'hFF);
        chk("R4 bad length ignored", int'(irq_n), 1);
        run_cmd(0, 1, 8'h04);
        chk("R4 R1 tick unmasked", int'(irq_n), 0);
        run_cmd(1, 0, 0);
        chk("R6 tick pending in reply", int'(rb[0] & 8'h04), 8'h04);
        chk("R6 irq after ack", int'(irq_n), 1);
        run_cmd(0, 1, 8'h03);
    endtask

    task automatic t_explicit();
        buf_wr(0, 8'hA1); buf_wr(1, 8'hB2); buf_wr(2, 8'hC3);
        bus_ev(0, 3);
        chk("R9 R1 irq on explicit", int'(irq_n), 0);
        run_cmd(1, 2, 0);
        chk("R5 rejected ack no reply", rn, 0);
        chk("R5 pending kept", int'(irq_n), 0);
        run_cmd(1, 0, 0);
        chk("R7 R9 reply length", rn, 6);
        chk("R7 flag byte", int'(rb[0]), 8'h01);
        chk("R9 marker", int'(rb[1]), 8'h01);
        chk("R9 length byte", int'(rb[2]), 3);
        chk("R9 data0", int'(rb[3]), 8'hA1);
        chk("R9 data2", int'(rb[5]), 8'hC3);
        chk("R12 ready low while streaming", ready_bad, 0);
        chk("R7 bus bit cleared", int'(irq_n), 1);
        bus_ev(0, 0);
        run_cmd(1, 0, 0);
        chk("R9 empty reply length", rn, 2);
        chk("R9 empty marker", int'(rb[1]), 8'h00);
    endtask

    task automatic t_poll();
        buf_wr(0, 8'h11); buf_wr(1, 8'h22);
        bus_ev(1, 2);
        chk("R8 irq on poll", int'(irq_n), 0);
        buf_wr(0, 8'h99);
        bus_ev(1, 1);
        run_cmd(1, 0, 0);
        chk("R8 poll reply length", rn, 3);
        chk("R8 flag both bits", int'(rb[0]), 8'h03);
        chk("R10 write ignored while pending", int'(rb[1]), 8'h11);
        chk("R8 data1", int'(rb[2]), 8'h22);
        bus_ev(1, 0);
        chk("R8 empty poll ignored", int'(irq_n), 1);
        run_cmd(1, 0, 0);
        chk("R8 no bus bits after empty poll", int'(rb[0] & 8'h03), 0);
    endtask

    task automatic t_clamp();
        for (int i = 0; i < 4; i++) buf_wr(2'(i), 8'(8'h40 + i));
        bus_ev(0, 7);
        run_cmd(1, 0, 0);
        chk("R11 clamped reply length", rn, 7);
        chk("R11 clamped length byte", int'(rb[2]), DEPTH);
        chk("R11 last data", int'(rb[6]), 8'h43);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_tick();
        t_mask();
        t_explicit();
        t_poll();
        t_clamp();
        summary();
        $finish;
    end
endmodule